// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period Limit

This block is a 16-bit up-counting timer that produces pulse-width-modulated outputs from a single rising ramp. On every cycle where the tick-enable input is high, the counter steps up by one. When it has reached the period limit, it returns to zero on the next tick instead. A waveform-mode field selects where the period limit comes from. It can be one of three fixed powers-of-two-minus-one values, a capture register, or the active value of compare channel 0.

Each compare channel holds a pending value and an active value. A write lands in the pending copy. That copy moves to the active copy only on the tick at which the counter sits at the limit, so a new duty cycle or new period never tears a cycle in progress. The capture register has no pending copy and steers the limit at once. If software lowers it below the running count, the counter misses the limit and runs through the full 16-bit range before it can match. Sticky flags record the period wrap, the capture-source wrap and every compare match. Software clears them by writing ones.

Top module: `fpwm_timer`

## Requirements
- R1: Waveform codes 5, 6 and 7 make the limit 0x00FF, 0x01FF and 0x03FF. Any code other than 5, 6, 7, 14 or 15 makes the limit 0xFFFF. The limit in force is visible on `top_val`.
- R2: With waveform code 14, the limit equals the capture register, starting from the cycle after it is written.
- R3: With waveform code 15, the limit equals the active value of compare channel 0. A write to that channel leaves the limit unchanged until the next tick at the limit.
- R4: The counter advances by one on each cycle with `tick_en` high and holds its value when `tick_en` is low. On a tick where it equals the limit, it becomes 0.
- R5: If the capture register is written below the current count, the counter keeps rising to 0xFFFF, wraps to 0x0000, and only then matches the new limit.
- R6: On a tick at the limit, `ovf_flag` sets. In the same cycle, `cap_flag` also sets under code 14. Under code 15, compare flag 0 sets in that cycle.
- R7: A compare write becomes active only at the tick where the counter is at the limit.
- R8: Under codes 5, 6 and 7, compare writes are stored ANDed with the fixed limit, so bits above the resolution are zero.
- R9: Output mode 2 (non-inverted) gives an output that is high while count <= active compare value C. With C >= limit, the output stays high. A compare tick clears the output, and the tick at the limit sets it, with the set taking priority.
- R10: Output mode 3 gives the complement of the mode 2 waveform. Output modes 0 and 1 drive the output low.
- R11: Flags are sticky and clear when a one is written to their bit in the flag register. A flag that is set and cleared in the same cycle stays set. Flag register bits: 0 = overflow, 1 = capture, 2+i = compare channel i.
- R12: Register select: 0 is the mode register, with bits [3:0] the waveform code and bits [5+2i:4+2i] the output mode of channel i. 1 is capture, 2 is flag clear, and 3+i is compare channel i. Reset gives count 0, code 5, all output modes 0, all compare and capture registers 0, outputs low and flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| top_val | output | 16 | Period limit in force |
| pwm_out | output | NUM_CH | Compare waveform outputs |
| ovf_flag | output | 1 | Sticky period-wrap flag |
| cap_flag | output | 1 | Sticky capture-limit flag |
| cmp_flag | output | NUM_CH | Sticky compare-match flags |

## Verification
The bench sweeps every compare value from 0 to two beyond a limit of 7, in both polarities. Each count of a full period is checked against count <= C. A design that gave the compare match priority over the restart would show a one-tick glitch low when C equals the limit. A design that compared with a strict inequality would shift every duty cycle by one. The capture-limit overrun is timed tick by tick across the full 16-bit wrap. A design that clamped the counter, or that reloaded at the lower limit, would wrap tens of thousands of ticks early. The compare-channel-0 limit is checked before and after the limit tick, which exposes a design that applies the write immediately. Fixed-mode masking is checked through the duty cycle, because an unmasked value above 0xFF would hold the output high for the whole period.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int CNT_W = 16;
  localparam int WGM_W = 4;
  localparam int OM_W  = 2;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [WGM_W-1:0] wgm_t;
  typedef logic [OM_W-1:0]  om_t;

  localparam wgm_t WGM_FIX8   = 4'd5;
  localparam wgm_t WGM_FIX9   = 4'd6;
  localparam wgm_t WGM_FIX10  = 4'd7;
  localparam wgm_t WGM_CAPTOP = 4'd14;
  localparam wgm_t WGM_CMPTOP = 4'd15;
  localparam wgm_t WGM_RESET  = WGM_FIX8;

  localparam om_t OM_OFF    = 2'd0;
  localparam om_t OM_NONINV = 2'd2;
  localparam om_t OM_INV    = 2'd3;

  localparam cnt_t CNT_MAX = '1;

  // Limit for the fixed-resolution codes; anything else runs the full range.
  function automatic cnt_t fixed_top(input wgm_t m);
    case (m)
      WGM_FIX8:  fixed_top = cnt_t'(16'h00FF);
      WGM_FIX9:  fixed_top = cnt_t'(16'h01FF);
      WGM_FIX10: fixed_top = cnt_t'(16'h03FF);
      default:   fixed_top = CNT_MAX;
    endcase
  endfunction

  function automatic logic is_fixed(input wgm_t m);
    is_fixed = (m == WGM_FIX8) || (m == WGM_FIX9) || (m == WGM_FIX10);
  endfunction

  function automatic cnt_t top_select(input wgm_t m, input cnt_t cap, input cnt_t cmpa);
    case (m)
      WGM_CAPTOP: top_select = cap;
      WGM_CMPTOP: top_select = cmpa;
      default:    top_select = fixed_top(m);
    endcase
  endfunction

  // Compare writes in fixed modes lose the bits above the resolution.
  function automatic cnt_t write_mask(input wgm_t m, input cnt_t d);
    write_mask = is_fixed(m) ? (d & fixed_top(m)) : d;
  endfunction

  // Next waveform level; restart takes priority over a coincident match.
  function automatic logic wave_next(input om_t om, input logic cur,
                                     input logic restart, input logic match);
    case (om)
      OM_NONINV: wave_next = restart ? 1'b1 : (match ? 1'b0 : cur);
      OM_INV:    wave_next = restart ? 1'b0 : (match ? 1'b1 : cur);
      default:   wave_next = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fpwm_counter.sv
module fpwm_counter
  import fpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  wgm_t wgm,
  input  cnt_t cap_top,
  input  cnt_t cmpa_top,
  output cnt_t count,
  output cnt_t top_val,
  output logic at_top
);
  assign top_val = top_select(wgm, cap_top, cmpa_top);
  assign at_top  = tick_en && (count == top_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (tick_en) count <= at_top ? '0 : count + cnt_t'(1);
  end

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (count == '0));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));
  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !at_top) |=> (count == $past(count) + cnt_t'(1)));
endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
  import fpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  cnt_t wr_val,
  input  logic tick_en,
  input  logic at_top,
  input  cnt_t count,
  input  om_t  om,
  output cnt_t cmp_act,
  output logic match,
  output logic pwm
);
  cnt_t cmp_pend;

  assign match = tick_en && (count == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_pend <= '0;
      cmp_act  <= '0;
      pwm      <= 1'b0;
    end else begin
      if (wr_stb) cmp_pend <= wr_val;
      if (at_top) cmp_act  <= cmp_pend;
      pwm <= wave_next(om, pwm, at_top, match);
    end
  end

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_top |=> $stable(cmp_act));
  // R9
  restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && om == OM_NONINV) |=> pwm);
  // R10
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && om == OM_INV) |=> !pwm);
endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags
  import fpwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ovf,
  input  logic              set_cap,
  input  logic [NUM_CH-1:0] set_cmp,
  input  logic              clr_stb,
  input  logic [NUM_CH+1:0] clr_bits,
  output logic              ovf_flag,
  output logic              cap_flag,
  output logic [NUM_CH-1:0] cmp_flag
);
  logic [NUM_CH+1:0] flags_q, set_vec, clr_vec;

  assign set_vec = {set_cmp, set_cap, set_ovf};
  assign clr_vec = clr_stb ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  assign ovf_flag = flags_q[0];
  assign cap_flag = flags_q[1];
  assign cmp_flag = flags_q[NUM_CH+1:2];

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> ovf_flag);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(clr_stb && clr_bits[0])) |=> ovf_flag);
  // R11
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && clr_bits[0] && !set_ovf) |=> !ovf_flag);
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int SEL_W  = $clog2(NUM_CH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [15:0]       wr_data,
  output logic [15:0]       count,
  output logic [15:0]       top_val,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              ovf_flag,
  output logic              cap_flag,
  output logic [NUM_CH-1:0] cmp_flag
);
  localparam int SEL_MODE = 0;
  localparam int SEL_CAP  = 1;
  localparam int SEL_FLAG = 2;
  localparam int SEL_CMP0 = 3;
  localparam int OM_LSB   = WGM_W;

  wgm_t wgm;
  om_t  om [NUM_CH];
  cnt_t cap_reg;
  cnt_t cmp_act [NUM_CH];
  logic [NUM_CH-1:0] match_vec;
  logic at_top;
  logic wr_mode, wr_cap, wr_flag;

  assign wr_mode = wr_en && (wr_sel == SEL_W'(SEL_MODE));
  assign wr_cap  = wr_en && (wr_sel == SEL_W'(SEL_CAP));
  assign wr_flag = wr_en && (wr_sel == SEL_W'(SEL_FLAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgm     <= WGM_RESET;
      cap_reg <= '0;
    end else begin
      if (wr_mode) wgm     <= wr_data[WGM_W-1:0];
      if (wr_cap)  cap_reg <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr_cmp;
    assign wr_cmp = wr_en && (wr_sel == SEL_W'(SEL_CMP0 + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       om[i] <= OM_OFF;
      else if (wr_mode) om[i] <= wr_data[OM_LSB + OM_W*i +: OM_W];
    end

    fpwm_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_cmp),
      .wr_val  (write_mask(wgm, wr_data)),
      .tick_en (tick_en),
      .at_top  (at_top),
      .count   (count),
      .om      (om[i]),
      .cmp_act (cmp_act[i]),
      .match   (match_vec[i]),
      .pwm     (pwm_out[i])
    );
  end

  fpwm_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wgm      (wgm),
    .cap_top  (cap_reg),
    .cmpa_top (cmp_act[0]),
    .count    (count),
    .top_val  (top_val),
    .at_top   (at_top)
  );

  fpwm_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ovf  (at_top),
    .set_cap  (at_top && (wgm == WGM_CAPTOP)),
    .set_cmp  (match_vec),
    .clr_stb  (wr_flag),
    .clr_bits (wr_data[NUM_CH+1:0]),
    .ovf_flag (ovf_flag),
    .cap_flag (cap_flag),
    .cmp_flag (cmp_flag)
  );

  // R6
  cap_with_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && wgm == WGM_CAPTOP) |=> (cap_flag && ovf_flag));
  // R6
  cmpa_with_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && wgm == WGM_CMPTOP) |=> (cmp_flag[0] && ovf_flag));
  // R2
  cap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cap && !wr_mode && wgm == WGM_CAPTOP) |=> (top_val == $past(wr_data)));
endmodule

// File: tb/sim_fpwm_timer.sv
module sim_fpwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count, top_val;
  logic [NCH-1:0] pwm_out, cmp_flag;
  logic ovf_flag, cap_flag;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  fpwm_timer #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .count(count), .top_val(top_val),
    .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cap_flag(cap_flag),
    .cmp_flag(cmp_flag)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    wr_sel = s; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mode_word(input int wgm, input int om0, input int om1);
    return 16'(wgm | (om0 << 4) | (om1 << 6));
  endfunction

  initial begin
    wait (cyc == 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int prev;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R12 reset state
    chk("R12 count", count, 0);
    chk("R12 top", top_val, 16'h00FF);
    chk("R12 pwm", pwm_out, 0);
    chk("R12 flags", {ovf_flag, cap_flag, cmp_flag}, 0);

    // R3 limit from compare channel 0
    wr(3'd0, mode_word(15, 2, 0));
    chk("R3 top before load", top_val, 0);
    wr(3'd3, 16'd20);
    chk("R3 top still pending", top_val, 0);
    tick_en = 1'b1; step(); tick_en = 1'b0;
    chk("R3 top after load", top_val, 20);
    wr(3'd2, 16'h001F);
    chk("R11 all cleared", {ovf_flag, cap_flag, cmp_flag}, 0);
    tick_en = 1'b1;
    n = 0;
    while (count != 16'd20 && n < 100) begin step(); n++; end
    chk("R4 ticks to limit", n, 20);
    chk("R6 no ovf before limit tick", ovf_flag, 0);
    step();
    chk("R4 wrap to zero", count, 0);
    chk("R6 ovf at limit", ovf_flag, 1);
    chk("R6 cmp0 with ovf", cmp_flag[0], 1);
    chk("R6 no cap flag in code 15", cap_flag, 0);
    chk("R9 cmp0 at limit stays high", pwm_out[0], 1);
    repeat (3) step();
    tick_en = 1'b0;
    wr(3'd3, 16'd10);
    chk("R7 limit unchanged after write", top_val, 20);
    tick_en = 1'b1;
    n = 0;
    while (count != 16'd0 && n < 100) begin step(); n++; end
    chk("R7 limit reloaded at wrap", top_val, 10);
    tick_en = 1'b0;

    // R2 capture limit, R9/R10 duty sweep
    wr(3'd0, mode_word(14, 0, 2));
    wr(3'd1, 16'd7);
    chk("R2 capture limit immediate", top_val, 7);
    wr(3'd2, 16'h001F);
    for (int inv = 0; inv < 2; inv++) begin
      wr(3'd0, mode_word(14, 0, 2 + inv));
      for (int c = 0; c < 10; c++) begin
        wr(3'd4, 16'(c));
        tick_en = 1'b1;
        repeat (20) step();
        for (int k = 0; k < 16; k++) begin
          chk("R4 count within limit", count <= 16'd7, 1);
          chk(inv ? "R10 inverted duty" : "R9 non-inverted duty",
              pwm_out[1], ((count <= 16'(c)) ? 1'b1 : 1'b0) ^ inv[0]);
          step();
        end
        tick_en = 1'b0;
        chk("R10 output mode 0 low", pwm_out[0], 0);
      end
    end
    chk("R6 cap flag in code 14", cap_flag, 1);

    // R5 capture overrun
    wr(3'd1, 16'd200);
    tick_en = 1'b1;
    n = 0;
    while (count != 16'd100 && n < 300) begin step(); n++; end
    tick_en = 1'b0;
    wr(3'd1, 16'd50);
    tick_en = 1'b1;
    n = 0;
    while (count != 16'd0 && n < 70000) begin step(); n++; end
    chk("R5 ticks through full wrap", n, 65536 - 100);
    repeat (50) step();
    chk("R5 reaches new limit", count, 50);
    step();
    chk("R5 wraps at new limit", count, 0);
    tick_en = 1'b0;

    // R1 fixed limits
    wr(3'd0, mode_word(6, 0, 2));  chk("R1 code 6", top_val, 16'h01FF);
    wr(3'd0, mode_word(7, 0, 2));  chk("R1 code 7", top_val, 16'h03FF);
    wr(3'd0, mode_word(9, 0, 2));  chk("R1 unlisted code", top_val, 16'hFFFF);
    wr(3'd0, mode_word(5, 0, 2));  chk("R1 code 5", top_val, 16'h00FF);

    // R8 masking seen through duty cycle
    wr(3'd4, 16'h0134);
    tick_en = 1'b1;
    repeat (600) step();
    prev = count;
    for (int k = 0; k < 256; k++) begin
      step();
      if (count == 0) chk("R1 wrap from 0xFF", prev, 255);
      else if (k % 16 == 0) chk("R4 increment", count, prev + 1);
      if (k % 8 == 0) chk("R8 masked duty", pwm_out[1], (count <= 16'h34) ? 1'b1 : 1'b0);
      prev = count;
    end

    // R4 hold
    tick_en = 1'b0;
    prev = count;
    n = pwm_out;
    repeat (5) step();
    chk("R4 hold count", count, prev);
    chk("R4 hold pwm", pwm_out, n);

    // R11 write-one-to-clear
    chk("R11 ovf set before clear", ovf_flag, 1);
    wr(3'd2, 16'h0001);
    chk("R11 ovf cleared", ovf_flag, 0);
    chk("R11 cmp1 kept", cmp_flag[1], 1);
    wr(3'd2, 16'h001E);
    chk("R11 rest cleared", {ovf_flag, cap_flag, cmp_flag}, 0);

    // R10 output disabled
    wr(3'd0, mode_word(5, 0, 0));
    tick_en = 1'b1;
    repeat (3) step();
    chk("R10 mode 0 low", pwm_out, 0);
    tick_en = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule